// File: doc/BRIEF.md
# PCIe Hot-Reset Link-Training Gate

This block sits in the client register space of a PCIe endpoint controller and drives the enable input of the link training state machine. When a hot reset or a link-down reset arrives, it can hold link training off. Software then has time to reprogram core registers while the link is still down. When software has finished, it writes a "done" command and training resumes. The same event also sets a sticky status bit. That bit drives an interrupt until software clears it.

Software configures the block through a small register port. The port performs a single-cycle write and returns read data combinationally. The control register and the interrupt mask register take masked writes: the upper 16 bits of the written word select which of the lower 16 bits change. An endpoint bring-up sequence sets the enhanced mode bit and the delay-arm bit together in one masked write. Every pin is a plain control or status signal.

Top module: `hrg_link_gate`

## Requirements
- R1: After reset, `ltssm_en` is 0, `link_rst_irq` is 0, and the control, status and mask registers all read as 0.
- R2: A write to the control register (0x180) or to the mask register (0x014) changes bit n of the low half only when bit n+16 of the written word is 1. Other bits keep their value. The upper 16 bits always read as 0.
- R3: Control bit 0 is the software training enable, bit 1 arms the delay, and bit 4 selects enhanced mode. While bit 0 is 0, `ltssm_en` is 0.
- R4: If bit 1 and bit 4 are both 1 when `link_rst_evt` is sampled, a hold is set. From the next cycle `ltssm_en` is 0, and control bit 8 (read-only) reads 1 while the hold lasts.
- R5: If bit 1 or bit 4 is 0, `link_rst_evt` does not set the hold, and `ltssm_en` keeps following bit 0.
- R6: A control write with bits 3 and 19 both set releases the hold in the next cycle. Bit 3 always reads 0. The command has no effect when no hold is set. Clearing bit 1 or bit 4 does not release a hold.
- R7: If `link_rst_evt` and a done command fall in the same cycle while armed, the event wins and the hold stays set.
- R8: Status register (0x010) bit 0 is set by `link_rst_evt` and is sticky. Writing 1 to it clears it, with no mask half involved. Writing 0 has no effect. A set and a clear in the same cycle leave it at 1.
- R9: `link_rst_irq` is high exactly while status bit 0 is 1 and mask bit 0 (register 0x014, where 1 masks the interrupt) is 0. It goes low in the cycle after the clear write.
- R10: The done command does not stay in effect. After a release, the next armed event holds training off again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_rst_evt | input | 1 | One-cycle pulse on a hot reset or link-down reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address for a read or a write |
| reg_wdata | input | 32 | Write data: mask in the upper half, value in the lower half |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ltssm_en | output | 1 | Enable to the link training state machine |
| link_rst_irq | output | 1 | Level interrupt for a pending link reset event |

## Verification
Two functions can land on the same clock edge.

- **Event and release.** A link reset event can coincide with the software done command. The bench drives `link_rst_evt` in the same cycle as the masked done write, for every setting of arm, enhanced mode and software enable. It then expects the hold flag and `ltssm_en` to reflect the event, not the release.
- **Event and clear.** The status set can meet a write-1-to-clear. The bench drives both together and expects the status bit, and therefore the interrupt, to stay set.

// File: rtl/hrg_pkg.sv
package hrg_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  // control register bit positions
  localparam int B_SWEN = 0;
  localparam int B_ARM  = 1;
  localparam int B_DONE = 3;
  localparam int B_ENH  = 4;
  localparam int B_HOLD = 8;

  // implemented storage bits
  localparam logic [HALF_W-1:0] CTRL_IMPL = HALF_W'((1 << B_SWEN) | (1 << B_ARM) | (1 << B_ENH));
  localparam logic [HALF_W-1:0] MASK_IMPL = HALF_W'(1);
endpackage

// File: rtl/hrg_mask_reg.sv
module hrg_mask_reg #(
  parameter int           W    = 16,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_ff
      logic b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   b <= RST[i];
        else if (we && wdata[W + i])  b <= wdata[i];
      end
      assign q[i] = b;
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hrg_evt_status.sv
module hrg_evt_status #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] mask,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_eff) | evt;
  end

  assign irq = |(stat & ~mask);
endmodule

// File: rtl/hrg_train_hold.sv
module hrg_train_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic arm,
  input  logic enh,
  input  logic done,
  input  logic sw_en,
  output logic hold,
  output logic ltssm_en
);
  logic trig;

  assign trig = evt && arm && enh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold <= 1'b0;
    else if (trig) hold <= 1'b1;
    else if (done) hold <= 1'b0;
  end

  assign ltssm_en = sw_en && !hold;
endmodule

// File: rtl/hrg_link_gate.sv
module hrg_link_gate
  import hrg_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h180,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h010,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_rst_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ltssm_en,
  output logic              link_rst_irq
);
  localparam int NUM_EVT = 1;

  logic              ctrl_we, mask_we, stat_we;
  logic [HALF_W-1:0] ctrl_q, mask_q;
  logic [NUM_EVT-1:0] stat_q;
  logic              done_pulse, hold_q;
  logic              sw_en, arm, enh;

  assign ctrl_we = reg_wr && (reg_addr == CTRL_ADDR);
  assign mask_we = reg_wr && (reg_addr == MASK_ADDR);
  assign stat_we = reg_wr && (reg_addr == STAT_ADDR);

  // done is a command: acted on once, never stored
  assign done_pulse = ctrl_we && reg_wdata[HALF_W + B_DONE] && reg_wdata[B_DONE];

  hrg_mask_reg #(.W(HALF_W), .IMPL(CTRL_IMPL), .RST('0)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(reg_wdata), .q(ctrl_q)
  );

  hrg_mask_reg #(.W(HALF_W), .IMPL(MASK_IMPL), .RST('0)) i_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(reg_wdata), .q(mask_q)
  );

  assign sw_en = ctrl_q[B_SWEN];
  assign arm   = ctrl_q[B_ARM];
  assign enh   = ctrl_q[B_ENH];

  hrg_evt_status #(.N(NUM_EVT)) i_stat (
    .clk(clk), .rst_n(rst_n), .evt(link_rst_evt), .clr_we(stat_we),
    .clr_bits(reg_wdata[NUM_EVT-1:0]), .mask(mask_q[NUM_EVT-1:0]),
    .stat(stat_q), .irq(link_rst_irq)
  );

  hrg_train_hold i_hold (
    .clk(clk), .rst_n(rst_n), .evt(link_rst_evt), .arm(arm), .enh(enh),
    .done(done_pulse), .sw_en(sw_en), .hold(hold_q), .ltssm_en(ltssm_en)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[HALF_W-1:0] = ctrl_q;
      reg_rdata[B_HOLD]     = hold_q;
    end else if (reg_addr == STAT_ADDR) begin
      reg_rdata[NUM_EVT-1:0] = stat_q;
    end else if (reg_addr == MASK_ADDR) begin
      reg_rdata[HALF_W-1:0] = mask_q;
    end
  end
endmodule

// File: rtl/hrg_link_gate_chk.sv
module hrg_link_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic evt,
  input logic done,
  input logic arm,
  input logic enh,
  input logic sw_en,
  input logic hold,
  input logic ltssm_en,
  input logic stat,
  input logic mask,
  input logic irq
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ltssm_en && !irq && !hold));

  assert_sw_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> !ltssm_en);

  assert_armed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && arm && enh) |=> (hold && !ltssm_en));

  assert_no_hold_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !(evt && arm && enh)) |=> !hold);

  assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !evt) |=> !hold);

  assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !done) |=> hold);

  assert_evt_beats_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && arm && enh && done) |=> hold);

  assert_status_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> stat);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat && !mask));
endmodule

bind hrg_link_gate hrg_link_gate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .evt(link_rst_evt), .done(done_pulse),
  .arm(arm), .enh(enh), .sw_en(sw_en), .hold(hold_q), .ltssm_en(ltssm_en),
  .stat(stat_q[0]), .mask(mask_q[0]), .irq(link_rst_irq)
);

// File: tb/test_hrg_link_gate.sv
module test_hrg_link_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h180;
  localparam logic [11:0] A_STAT = 12'h010;
  localparam logic [11:0] A_MASK = 12'h014;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_rst_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ltssm_en, link_rst_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hrg_link_gate i_hrg_link_gate (
    .clk(clk), .rst_n(rst_n), .link_rst_evt(link_rst_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ltssm_en(ltssm_en), .link_rst_irq(link_rst_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive after a falling edge, return after the next falling edge
  task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic ev);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; link_rst_evt = ev;
    @(negedge clk);
    reg_wr = 1'b0; link_rst_evt = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    for (int c = 0; c < 16; c++) begin
      bit sw, arm, enh, coll, hold;
      logic [31:0] base;
      sw = c[0]; arm = c[1]; enh = c[2]; coll = c[3];
      hold = arm & enh;
      base = {27'b0, enh, 2'b00, arm, sw};
      do_reset();
      chk("R1 ltssm_en", {31'b0, ltssm_en}, 32'd0);
      chk("R1 irq", {31'b0, link_rst_irq}, 32'd0);
      rd(A_CTRL, v); chk("R1 ctrl", v, 32'd0);
      rd(A_STAT, v); chk("R1 stat", v, 32'd0);
      cyc(1'b1, A_CTRL, {16'h0013, base[15:0]}, 1'b0);
      chk("R3 ltssm follows sw", {31'b0, ltssm_en}, {31'b0, sw});
      rd(A_CTRL, v); chk("R2 ctrl readback", v, base);
      // event, optionally colliding with a done command (R7)
      cyc(coll, A_CTRL, 32'h0008_0008, 1'b1);
      chk("R4 R5 R7 ltssm after event", {31'b0, ltssm_en}, {31'b0, sw & ~hold});
      rd(A_CTRL, v); chk("R4 R7 hold flag", v, base | (32'(hold) << 8));
      rd(A_STAT, v); chk("R8 status set", v, 32'd1);
      chk("R9 irq raised", {31'b0, link_rst_irq}, 32'd1);
      cyc(1'b1, A_CTRL, 32'h0008_0008, 1'b0);
      chk("R6 ltssm after done", {31'b0, ltssm_en}, {31'b0, sw});
      rd(A_CTRL, v); chk("R6 done not stored", v, base);
      cyc(1'b1, A_STAT, 32'd1, 1'b0);
      chk("R9 irq cleared", {31'b0, link_rst_irq}, 32'd0);
      rd(A_STAT, v); chk("R8 status cleared", v, 32'd0);
    end

    // masked-write corners (R2)
    do_reset();
    cyc(1'b1, A_CTRL, 32'h0013_0013, 1'b0);
    rd(A_CTRL, v); chk("R2 set all", v, 32'h13);
    cyc(1'b1, A_CTRL, 32'h0002_0000, 1'b0);
    rd(A_CTRL, v); chk("R2 single bit", v, 32'h11);
    cyc(1'b1, A_CTRL, 32'h0000_FFFF, 1'b0);
    rd(A_CTRL, v); chk("R2 zero mask", v, 32'h11);
    cyc(1'b1, A_CTRL, 32'hFFFF_FFFF, 1'b0);
    rd(A_CTRL, v); chk("R2 R6 full write", v, 32'h13);
    cyc(1'b1, A_MASK, 32'h0001_0001, 1'b0);
    rd(A_MASK, v); chk("R2 mask reg", v, 32'h1);

    // interrupt masking (R9)
    cyc(1'b0, A_CTRL, 32'd0, 1'b1);
    rd(A_STAT, v); chk("R8 masked event", v, 32'd1);
    chk("R9 masked irq", {31'b0, link_rst_irq}, 32'd0);
    cyc(1'b1, A_MASK, 32'h0001_0000, 1'b0);
    chk("R9 unmask", {31'b0, link_rst_irq}, 32'd1);

    // W1C corners (R8)
    cyc(1'b1, A_STAT, 32'd0, 1'b0);
    rd(A_STAT, v); chk("R8 write zero", v, 32'd1);
    cyc(1'b1, A_STAT, 32'd1, 1'b1);
    rd(A_STAT, v); chk("R8 set beats clear", v, 32'd1);
    cyc(1'b1, A_STAT, 32'd1, 1'b0);
    rd(A_STAT, v); chk("R8 clear", v, 32'd0);
    chk("R9 low after clear", {31'b0, link_rst_irq}, 32'd0);

    // hold persistence and re-trigger (R6, R10)
    cyc(1'b1, A_CTRL, 32'h0002_0000, 1'b0);
    chk("R6 disarm keeps hold", {31'b0, ltssm_en}, 32'd0);
    rd(A_CTRL, v); chk("R6 hold flag", v, 32'h111);
    cyc(1'b1, A_CTRL, 32'h0008_0008, 1'b0);
    chk("R6 release", {31'b0, ltssm_en}, 32'd1);
    cyc(1'b1, A_CTRL, 32'h0002_0002, 1'b0);
    cyc(1'b0, A_CTRL, 32'd0, 1'b1);
    chk("R10 re-hold", {31'b0, ltssm_en}, 32'd0);
    cyc(1'b1, A_CTRL, 32'h0008_0008, 1'b0);
    chk("R10 release again", {31'b0, ltssm_en}, 32'd1);
    cyc(1'b1, A_CTRL, 32'h0008_0008, 1'b0);
    chk("R6 idle done", {31'b0, ltssm_en}, 32'd1);
    rd(A_CTRL, v); chk("R6 idle done ctrl", v, 32'h13);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule